// File: doc/BRIEF.md
# Counter Pattern Source and Stream Integrity Checker

This block is a built-in test pair for a framed sample stream that moves four complex samples per clock in a 128-bit word. The pattern source stands in for real data. In each sample, the real field carries a ramp counter that runs from 0 to 511 and then wraps to 0. The imaginary field carries a frame index that rises by one each time the ramp wraps.

The checker watches the stream as it is captured, over one capture window. A capture trigger arms it, and the window closes on the n-th frame marker, where n is the configured frame count. The checker takes the four lanes of every beat in order, lane 0 to lane 3. It keeps the previous sample from one beat to the next, so the checks cover steps that cross lane and beat boundaries.

The window may start in the middle of a source frame. For that reason the checker does not compare against one fixed ramp. It counts the wraps over the window and limits how many frame indices may mix within each captured frame. Four separate sticky flags report the error classes, and the beat number of the first fault is latched.

Top module: `ramp_integrity_pair`

## Requirements
- R1: While `src_en` is high, the source ramp base advances by 4 per clock, modulo 512. Lane i carries base+i in its real field. While `src_en` is low, `src_data` holds its value.
- R2: In every lane, the source's imaginary field carries the frame index. The index rises by one each time the ramp wraps from 511 to 0. After reset, the ramp base and the index are both 0.
- R3: Between consecutive checked samples (lane order 0..3, then on into the next beat), the real field must rise by exactly 1 or wrap from 511 to 0. Any other step sets `err_step`.
- R4: At every 511-to-0 wrap, the imaginary field after the wrap must equal the value before it plus one, with no modulo. A step from 0xFFFF to 0x0000 is therefore an error. A violation sets `err_incr`.
- R5: A captured frame is the set of samples from one `cap_last` beat up to the next. If a captured frame holds more than two distinct imaginary values, `err_mix` is set.
- R6: `win_done` rises on the beat that carries the `n_frames`-th `cap_last` of the window. On that beat, `err_wrap` is set if the number of wraps counted over the window differs from `n_frames`. An aligned start yields one wrap fewer than the frame count.
- R7: `err_any` and `first_err_beat` work together. `first_err_beat` latches the zero-based beat number, within the window, of the first beat that raised any error. All flags stay set until the next trigger.
- R8: Reset and `cap_trig` both clear every flag, `win_done` and `first_err_beat`. A trigger also arms the checker. The beat on the trigger cycle, beats before any trigger and beats after `win_done` are all ignored.
- R9: Lane i of both 128-bit words uses bits [32i+15:32i] for the real field and bits [32i+31:32i+16] for the imaginary field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_en | input | 1 | Advance the pattern by one beat |
| src_data | output | 128 | Pattern beat, four lanes |
| cap_trig | input | 1 | Start a capture window |
| cap_valid | input | 1 | Captured beat present |
| cap_data | input | 128 | Captured beat, four lanes |
| cap_last | input | 1 | Beat ends a captured frame |
| n_frames | input | 11 | Frames per window (at least 1) |
| err_step | output | 1 | Sticky ramp-step error |
| err_wrap | output | 1 | Sticky wrap-count error |
| err_incr | output | 1 | Sticky index-increment error |
| err_mix | output | 1 | Sticky frame-mixing error |
| err_any | output | 1 | Any error seen |
| first_err_beat | output | 20 | Window beat of the first error |
| win_done | output | 1 | Window closed |

## Verification
Suppose the previous sample carried across a beat boundary is wrong. A clean stream would then raise `err_step` one clock after the first beat of the window that follows, and `first_err_beat` would point at beat 0 or at a boundary beat. A wrong wrap or frame counter stays hidden until the closing frame marker, so it is seen only through `err_wrap` and `win_done` at the end of the window. For that reason the reference model is compared on every clock rather than only at the end. Faulty distinct-value tracking surfaces as `err_mix` on a clean stream, or as its absence when a single corrupted index is injected mid-frame.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
    localparam int LANES   = 4;
    localparam int FIELD_W = 16;
    localparam int SAMP_W  = 2 * FIELD_W;
    localparam int BEAT_DW = LANES * SAMP_W;

    // imaginary field in the upper half, real field in the lower half
    typedef struct packed {
        logic [FIELD_W-1:0] idx;
        logic [FIELD_W-1:0] cnt;
    } samp_t;

    typedef samp_t [LANES-1:0] beat_t;

    // distinct frame-index tracker for one captured frame
    typedef struct packed {
        logic [FIELD_W-1:0] v0;
        logic [FIELD_W-1:0] v1;
        logic [1:0]         nvals;
    } mixst_t;

    function automatic logic is_wrap(samp_t p, samp_t c, logic [FIELD_W-1:0] cmax);
        return (p.cnt == cmax) && (c.cnt == '0);
    endfunction

    function automatic logic step_ok(samp_t p, samp_t c, logic [FIELD_W-1:0] cmax);
        return (({1'b0, c.cnt} == {1'b0, p.cnt} + 17'd1) && (c.cnt <= cmax))
               || is_wrap(p, c, cmax);
    endfunction

    function automatic logic incr_ok(samp_t p, samp_t c);
        return {1'b0, c.idx} == {1'b0, p.idx} + 17'd1;
    endfunction

    function automatic logic mix_err(mixst_t s, logic [FIELD_W-1:0] x);
        return (s.nvals == 2'd2) && (x != s.v0) && (x != s.v1);
    endfunction

    function automatic mixst_t mix_next(mixst_t s, logic [FIELD_W-1:0] x);
        mixst_t r;
        r = s;
        if (s.nvals == 2'd0) begin
            r.v0    = x;
            r.nvals = 2'd1;
        end else if ((s.nvals == 2'd1) && (x != s.v0)) begin
            r.v1    = x;
            r.nvals = 2'd2;
        end
        return r;
    endfunction
endpackage

// File: rtl/ramp_source.sv
module ramp_source
    import ramp_pkg::*;
#(
    parameter int FRAME_LEN = 512
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    output beat_t beat
);
    localparam logic [FIELD_W-1:0] LAST_BASE = FIELD_W'(FRAME_LEN - LANES);

    logic [FIELD_W-1:0] base_q;
    logic [FIELD_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            idx_q  <= '0;
        end else if (en) begin
            if (base_q == LAST_BASE) begin
                base_q <= '0;
                idx_q  <= idx_q + 1'b1;
            end else begin
                base_q <= base_q + FIELD_W'(LANES);
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign beat[g].cnt = base_q + FIELD_W'(g);
        assign beat[g].idx = idx_q;
    end

    // R1
    src_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(beat));

    // R2
    src_idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> ((idx_q == $past(idx_q)) || (idx_q == $past(idx_q) + 1'b1)));
endmodule

// File: rtl/lane_scan.sv
module lane_scan
    import ramp_pkg::*;
#(
    parameter int FRAME_LEN = 512
) (
    input  beat_t      beat,
    input  samp_t      prev_in,
    input  logic       prev_ok,
    input  mixst_t     mix_in,
    output samp_t      prev_out,
    output mixst_t     mix_out,
    output logic       step_err,
    output logic       incr_err,
    output logic       mix_hit,
    output logic [2:0] wraps
);
    localparam logic [FIELD_W-1:0] CMAX = FIELD_W'(FRAME_LEN - 1);

    samp_t            pc [LANES+1];
    mixst_t           mc [LANES+1];
    logic [LANES-1:0] se, ie, me, wv;

    assign pc[0] = prev_in;
    assign mc[0] = mix_in;

    for (genvar g = 0; g < LANES; g++) begin : g_stage
        logic ok_g;
        assign ok_g      = (g == 0) ? prev_ok : 1'b1;
        assign wv[g]     = ok_g && is_wrap(pc[g], beat[g], CMAX);
        assign se[g]     = ok_g && !step_ok(pc[g], beat[g], CMAX);
        assign ie[g]     = wv[g] && !incr_ok(pc[g], beat[g]);
        assign me[g]     = mix_err(mc[g], beat[g].idx);
        assign mc[g+1]   = mix_next(mc[g], beat[g].idx);
        assign pc[g+1]   = beat[g];
    end

    assign prev_out = pc[LANES];
    assign mix_out  = mc[LANES];
    assign step_err = |se;
    assign incr_err = |ie;
    assign mix_hit  = |me;
    assign wraps    = 3'($countones(wv));
endmodule

// File: rtl/ramp_checker.sv
module ramp_checker
    import ramp_pkg::*;
#(
    parameter int FRAME_LEN = 512,
    parameter int NF_W      = 11,
    parameter int BEAT_W    = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic              valid,
    input  beat_t             data,
    input  logic              last,
    input  logic [NF_W-1:0]   n_frames,
    output logic              err_step,
    output logic              err_wrap,
    output logic              err_incr,
    output logic              err_mix,
    output logic              err_any,
    output logic [BEAT_W-1:0] first_beat,
    output logic              done
);
    localparam int CW = NF_W + 1;

    logic              armed, have_prev;
    samp_t             prev_q;
    mixst_t            mix_q;
    logic [CW-1:0]     wraps_q, frames_q;
    logic [BEAT_W-1:0] beat_q;

    samp_t         s_prev;
    mixst_t        s_mix;
    logic          s_step, s_incr, s_mix_hit;
    logic [2:0]    s_wraps;

    lane_scan #(.FRAME_LEN(FRAME_LEN)) u_scan (
        .beat     (data),
        .prev_in  (prev_q),
        .prev_ok  (have_prev),
        .mix_in   (mix_q),
        .prev_out (s_prev),
        .mix_out  (s_mix),
        .step_err (s_step),
        .incr_err (s_incr),
        .mix_hit  (s_mix_hit),
        .wraps    (s_wraps)
    );

    logic [CW-1:0] wraps_n, frames_n;
    logic          take, closing, wrap_bad, new_err;

    always_comb begin
        take     = valid && armed;
        wraps_n  = wraps_q + CW'(s_wraps);
        frames_n = frames_q + CW'(last);
        closing  = last && (frames_n == {1'b0, n_frames});
        wrap_bad = closing && (wraps_n != {1'b0, n_frames});
        new_err  = s_step || s_incr || s_mix_hit || wrap_bad;
    end

    always_ff @(posedge clk) begin
        if (rst || trig) begin
            armed      <= trig && !rst;
            have_prev  <= 1'b0;
            prev_q     <= '0;
            mix_q      <= '0;
            wraps_q    <= '0;
            frames_q   <= '0;
            beat_q     <= '0;
            err_step   <= 1'b0;
            err_wrap   <= 1'b0;
            err_incr   <= 1'b0;
            err_mix    <= 1'b0;
            err_any    <= 1'b0;
            first_beat <= '0;
            done       <= 1'b0;
        end else if (take) begin
            have_prev <= 1'b1;
            prev_q    <= s_prev;
            mix_q     <= last ? '0 : s_mix;
            wraps_q   <= wraps_n;
            frames_q  <= frames_n;
            beat_q    <= beat_q + 1'b1;
            err_step  <= err_step | s_step;
            err_incr  <= err_incr | s_incr;
            err_mix   <= err_mix | s_mix_hit;
            err_wrap  <= err_wrap | wrap_bad;
            if (new_err && !err_any) begin
                err_any    <= 1'b1;
                first_beat <= beat_q;
            end
            if (closing) begin
                armed <= 1'b0;
                done  <= 1'b1;
            end
        end
    end

    // R8
    trig_clear_chk: assert property (@(posedge clk) disable iff (rst)
        trig |=> (!err_step && !err_wrap && !err_incr && !err_mix && !err_any && !done));

    // R7
    sticky_any_chk: assert property (@(posedge clk) disable iff (rst)
        (err_any && !trig) |=> err_any);

    // R7
    first_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (err_any && !trig) |=> $stable(first_beat));

    // R6
    wrap_at_close_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_wrap) |-> $rose(done));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !trig) |=> ($stable(err_step) && $stable(err_mix) && $stable(err_incr)));
endmodule

// File: rtl/ramp_integrity_pair.sv
module ramp_integrity_pair
    import ramp_pkg::*;
#(
    parameter int FRAME_LEN = 512,
    parameter int NF_W      = 11,
    parameter int BEAT_W    = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               src_en,
    output logic [BEAT_DW-1:0] src_data,
    input  logic               cap_trig,
    input  logic               cap_valid,
    input  logic [BEAT_DW-1:0] cap_data,
    input  logic               cap_last,
    input  logic [NF_W-1:0]    n_frames,
    output logic               err_step,
    output logic               err_wrap,
    output logic               err_incr,
    output logic               err_mix,
    output logic               err_any,
    output logic [BEAT_W-1:0]  first_err_beat,
    output logic               win_done
);
    beat_t src_beat;
    beat_t cap_beat;

    assign src_data = src_beat;
    assign cap_beat = cap_data;

    ramp_source #(.FRAME_LEN(FRAME_LEN)) u_src (
        .clk  (clk),
        .rst  (rst),
        .en   (src_en),
        .beat (src_beat)
    );

    ramp_checker #(.FRAME_LEN(FRAME_LEN), .NF_W(NF_W), .BEAT_W(BEAT_W)) u_chk (
        .clk        (clk),
        .rst        (rst),
        .trig       (cap_trig),
        .valid      (cap_valid),
        .data       (cap_beat),
        .last       (cap_last),
        .n_frames   (n_frames),
        .err_step   (err_step),
        .err_wrap   (err_wrap),
        .err_incr   (err_incr),
        .err_mix    (err_mix),
        .err_any    (err_any),
        .first_beat (first_err_beat),
        .done       (win_done)
    );
endmodule

// File: tb/ramp_integrity_pair_bench.sv
module ramp_integrity_pair_bench;
    localparam int FL  = 512;
    localparam int NFW = 11;
    localparam int BW  = 20;
    localparam int LN  = 4;
    localparam int FB  = FL / LN;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           src_en = 1'b0;
    logic [127:0]   src_data;
    logic           cap_trig = 1'b0;
    logic           cap_valid = 1'b0;
    logic [127:0]   cap_data = '0;
    logic           cap_last = 1'b0;
    logic [NFW-1:0] n_frames = 11'd1;
    logic           err_step, err_wrap, err_incr, err_mix, err_any, win_done;
    logic [BW-1:0]  first_err_beat;

    always #2 clk = ~clk;

    ramp_integrity_pair #(.FRAME_LEN(FL), .NF_W(NFW), .BEAT_W(BW)) u_ramp_integrity_pair (
        .clk(clk), .rst(rst), .src_en(src_en), .src_data(src_data),
        .cap_trig(cap_trig), .cap_valid(cap_valid), .cap_data(cap_data),
        .cap_last(cap_last), .n_frames(n_frames),
        .err_step(err_step), .err_wrap(err_wrap), .err_incr(err_incr),
        .err_mix(err_mix), .err_any(err_any), .first_err_beat(first_err_beat),
        .win_done(win_done)
    );

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    int m_src_n = 0;
    int m_armed = 0, m_done = 0, m_have = 0, m_pc = 0, m_px = 0;
    int m_q[$];
    int m_wraps = 0, m_frames = 0, m_beat = 0;
    int m_es = 0, m_ew = 0, m_ei = 0, m_em = 0, m_any = 0, m_first = 0;

    task automatic chk(string tag, string nm, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, exp);
        end
    endtask

    // R9: lane i real at [32i+15:32i], imaginary at [32i+31:32i+16]
    function automatic logic [127:0] gen(int n, int base);
        logic [127:0] d;
        for (int i = 0; i < LN; i++) begin
            d[32*i +: 16]    = 16'((n + i) % FL);
            d[32*i+16 +: 16] = 16'((base + (n + i) / FL) & 32'hFFFF);
        end
        return d;
    endfunction

    task automatic model_clear(int arm);
        m_armed = arm; m_done = 0; m_have = 0; m_q.delete();
        m_wraps = 0; m_frames = 0; m_beat = 0;
        m_es = 0; m_ew = 0; m_ei = 0; m_em = 0; m_any = 0; m_first = 0;
    endtask

    task automatic model_beat(logic [127:0] d, logic last);
        int newe;
        newe = 0;
        for (int i = 0; i < LN; i++) begin
            int c, x, found;
            c = int'(d[32*i +: 16]);
            x = int'(d[32*i+16 +: 16]);
            if (m_have != 0) begin
                if (!(((c == m_pc + 1) && (c <= FL - 1)) || ((m_pc == FL - 1) && (c == 0)))) begin
                    m_es = 1; newe = 1;
                end
                if ((m_pc == FL - 1) && (c == 0)) begin
                    m_wraps++;
                    if (x != m_px + 1) begin m_ei = 1; newe = 1; end
                end
            end
            found = 0;
            foreach (m_q[j]) if (m_q[j] == x) found = 1;
            if (found == 0) m_q.push_back(x);
            if (m_q.size() > 2) begin m_em = 1; newe = 1; end
            m_pc = c; m_px = x; m_have = 1;
        end
        if (last) begin
            m_frames++;
            m_q.delete();
            if (m_frames == int'(n_frames)) begin
                m_done = 1; m_armed = 0;
                if (m_wraps != int'(n_frames)) begin m_ew = 1; newe = 1; end
            end
        end
        if ((newe != 0) && (m_any == 0)) begin m_any = 1; m_first = m_beat; end
        m_beat++;
    endtask

    // drive one clock of stimulus at a falling edge; model holds the post-edge values
    task automatic clk_step(logic trg, logic vld, logic [127:0] d, logic lst, logic en);
        cap_trig = trg; cap_valid = vld; cap_data = d; cap_last = lst; src_en = en;
        if (trg) model_clear(1);
        else if (vld && (m_armed != 0)) model_beat(d, lst);
        if (en) m_src_n += LN;
        @(negedge clk);
    endtask

    // compare every clock
    always @(posedge clk) begin
        #1;
        chk("R9", "src_data", src_data, gen(m_src_n, 0));
        chk("R1", "src_lane0_real", 128'(src_data[15:0]), 128'(m_src_n % FL));
        chk("R2", "src_lane0_imag", 128'(src_data[31:16]), 128'((m_src_n / FL) & 32'hFFFF));
        chk("R3", "err_step", 128'(err_step), 128'(m_es));
        chk("R4", "err_incr", 128'(err_incr), 128'(m_ei));
        chk("R5", "err_mix", 128'(err_mix), 128'(m_em));
        chk("R6", "err_wrap", 128'(err_wrap), 128'(m_ew));
        chk("R6", "win_done", 128'(win_done), 128'(m_done));
        chk("R7", "err_any", 128'(err_any), 128'(m_any));
        chk("R7", "first_err_beat", 128'(first_err_beat), 128'(m_first));
    end

    task automatic run_window(int start_n, int base, int nf, int bad_beat, int bad_lane,
                              int mode, int extra, bit use_src);
        n_frames = NFW'(nf);
        clk_step(1'b1, 1'b1, {4{32'hDEAD_BEEF}}, 1'b1, 1'b0);
        // R8: trigger beat ignored, all cleared
        chk("R8", "flags_after_trig", 128'({err_step, err_wrap, err_incr, err_mix, err_any, win_done}), 128'(0));
        for (int k = 0; k < nf * FB; k++) begin
            logic [127:0] d;
            int n;
            if (use_src && (k % 37 == 5)) clk_step(1'b0, 1'b0, '0, 1'b0, 1'b0);
            n = use_src ? m_src_n : start_n + k * LN;
            d = gen(n, use_src ? 0 : base);
            if (k == bad_beat && mode == 1) d[32*bad_lane +: 16] = d[32*bad_lane +: 16] + 16'd2;
            if (k == bad_beat && mode == 2) d[32*bad_lane+16 +: 16] = d[32*bad_lane+16 +: 16] + 16'd5;
            clk_step(1'b0, 1'b1, d, ((k + 1) % FB) == 0, use_src);
        end
        for (int e = 0; e < extra; e++) clk_step(1'b0, 1'b1, {4{32'h1234_4321}}, 1'b1, 1'b0);
    endtask

    initial begin
        model_clear(0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        chk("R8", "reset_flags", 128'({err_step, err_wrap, err_incr, err_mix, err_any, win_done}), 128'(0));
        chk("R2", "reset_src", src_data[31:0], 128'(0));
        // R8: beats before any trigger ignored
        for (int i = 0; i < 5; i++) clk_step(1'b0, 1'b1, {4{32'hFFFF_0007}}, 1'b1, 1'b0);
        chk("R8", "pre_trig_ignored", 128'(err_any), 128'(0));
        // R1: advance source to an offset of 100 samples, with a stall
        for (int i = 0; i < 25; i++) clk_step(1'b0, 1'b0, '0, 1'b0, 1'b1);
        clk_step(1'b0, 1'b0, '0, 1'b0, 1'b0);
        chk("R1", "src_offset", 128'(src_data[15:0]), 128'(100));
        // clean source window, 3 frames, mid-frame start
        run_window(0, 0, 3, -1, 0, 0, 0, 1'b1);
        chk("R6", "clean_done", 128'({win_done, err_wrap, err_any}), 128'(3'b100));
        // R3: bumped ramp at beat 40 lane 2
        run_window(200, 7, 2, 40, 2, 1, 0, 1'b0);
        chk("R3", "step_flag", 128'({err_step, first_err_beat}), {107'd0, 1'b1, 20'd40});
        // R5: third index injected mid-frame at beat 80
        run_window(1000, 3, 2, 80, 1, 2, 0, 1'b0);
        chk("R5", "mix_only", 128'({err_mix, err_step, err_incr, err_wrap}), 128'(4'b1000));
        // R4: index 0xFFFF rolls to 0 at the wrap
        run_window(300, 32'hFFFF, 2, -1, 0, 0, 0, 1'b0);
        chk("R4", "incr_rollover", 128'({err_incr, err_step, err_mix}), 128'(3'b100));
        // R6: aligned start gives one wrap fewer than frames
        run_window(0, 5, 2, -1, 0, 0, 0, 1'b0);
        chk("R6", "wrap_short", 128'({err_wrap, win_done, first_err_beat}), {106'd0, 2'b11, 20'd255});
        // R8: garbage after close ignored
        run_window(4, 0, 1, -1, 0, 0, 10, 1'b0);
        chk("R8", "post_done_ignored", 128'({err_any, win_done}), 128'(2'b01));
        clk_step(1'b0, 1'b0, '0, 1'b0, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule